// File: doc/BRIEF.md
# Differential-Phase Dual-Output AM Synthesizer

This block produces an amplitude-modulated carrier from two one-bit digital outputs. A single phase accumulator advances by a frequency control word every active cycle. Two slicing paths take that running phase, shift it by a phase offset in opposite directions (plus offset on one path, minus offset on the other), add a dither value, and keep only the most significant bit. The two bits share the carrier frequency but sit at phases +d and −d. A pair of resistors outside the chip sums them into a three-level waveform whose envelope follows cos(d).

The offset input arrives already encoded. For a desired amplitude s, the caller supplies d = arccos(s/2) scaled to a full turn of 2^16. The sum then carries s·sin(ωt) with no residual phase modulation.

A mode input chooses how the dither is applied:
- **Mirrored:** one generator dithers path A, and path B receives the bitwise complement of the same value, so part of the dither noise cancels in the analog sum.
- **Independent:** each path has its own generator.
- **Simple:** path A has no offset and path B carries the whole offset. The offset is then encoded as 2·arccos(s/2), which also shifts the carrier by d/2.
- **Undithered:** no dither is applied.

Top module: `diffphase_am_synth`

## Requirements
- R1: While rst_n is low, both outputs are 0 immediately (asynchronous). Reset release is synchronised: the outputs stay 0 through the second rising edge after rst_n rises, and the first active edge is the third.
- R2: The phase starts at 0 and advances by fcw at each active edge, modulo 2^16. The output registered at active edge k (k counted from 0) is computed from phase k·fcw.
- R3: When mode is 3 (undithered), out_a = MSB(phase + d) and out_b = MSB(phase − d), with 16-bit wrap-around.
- R4: There are two 15-bit dither generators. Each shifts left with new bit 0 = bit14 XOR bit13. Their seeds are 0x2ACE (generator A) and 0x1D87 (generator B). Both advance at every active edge in every mode, and the dither value is the whole 15-bit state zero-extended to 16 bits. Neither state is ever zero, and the two states never coincide.
- R5: When mode is 0 (mirrored), out_a = MSB(phase + d + rA) and out_b = MSB(phase − d + (0x7FFF − rA)).
- R6: When mode is 1 (independent), out_a = MSB(phase + d + rA) and out_b = MSB(phase − d + rB).
- R7: When mode is 2 (simple), out_a = MSB(phase + rA) and out_b = MSB(phase + d + rA). With d = 0 the two outputs are equal.
- R8: Both outputs are registered on the same edge. A change of d or mode between edges leaves the outputs unchanged until the next active edge, which reflects the new values.
- R9: Changing mode or fcw while running neither resets nor skips the phase or the dither generators.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fcw | input | 16 | Frequency control word added to the phase each cycle |
| phase_off | input | 16 | Encoded phase offset d (a full turn is 2^16) |
| mode | input | 2 | 0 mirrored, 1 independent, 2 simple, 3 undithered |
| out_a | output | 1 | Path A one-bit carrier |
| out_b | output | 1 | Path B one-bit carrier |

## Verification
The bench targets the following corner cases:
- **Offset at a quarter and at half a turn with zero fcw.** A sign error on the subtracting path would give equal outputs where they must differ.
- **Zero fcw and zero offset in mirrored mode.** Both outputs must stay low. An offset-by-one complement would push path B across its MSB.
- **Wrapping control words and offsets.** These catch truncation mistakes.
- **Mid-run changes of d and mode.** These expose a design that reacts before the edge, registers the two outputs a cycle apart, or restarts the accumulator or the generators on a mode change.
- **Reset asserted between edges.** This must clear the outputs at once.

// File: rtl/dam_pkg.sv
package dam_pkg;
  typedef enum logic [1:0] {
    MODE_MIRROR = 2'd0,
    MODE_INDEP  = 2'd1,
    MODE_SIMPLE = 2'd2,
    MODE_PLAIN  = 2'd3
  } dmode_e;
endpackage

// File: rtl/dam_reset_sync.sv
module dam_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/dam_phase_acc.sv
module dam_phase_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] step,
  output logic [W-1:0] phase
);
  logic [W-1:0] phase_q, phase_d;

  always_comb phase_d = phase_q + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/dam_lfsr.sv
module dam_lfsr #(
  parameter int unsigned W    = 15,
  parameter logic [W-1:0] TAPS = 15'h6000,
  parameter logic [W-1:0] SEED = 15'h2ACE
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q, state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/dam_path.sv
module dam_path #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] phase,
  input  logic [W-1:0] offset,
  input  logic [W-2:0] dither,
  output logic         bit_o
);
  logic [W-1:0] sum;

  always_comb begin
    sum   = phase + offset + {1'b0, dither};
    bit_o = sum[W-1];
  end
endmodule

// File: rtl/diffphase_am_synth.sv
module diffphase_am_synth #(
  parameter int unsigned  ACC_W     = 16,
  parameter logic [14:0]  DITH_TAPS = 15'h6000,
  parameter logic [14:0]  SEED_A    = 15'h2ACE,
  parameter logic [14:0]  SEED_B    = 15'h1D87
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] fcw,
  input  logic [ACC_W-1:0] phase_off,
  input  logic [1:0]       mode,
  output logic             out_a,
  output logic             out_b
);
  import dam_pkg::*;

  localparam int unsigned DW = ACC_W - 1;
  localparam int unsigned NPATH = 2;

  logic             rst_core_n;
  logic [ACC_W-1:0] phase;
  logic [DW-1:0]    lfsr_a_state, lfsr_b_state;
  logic [ACC_W-1:0] off_sel  [NPATH];
  logic [DW-1:0]    dith_sel [NPATH];
  logic [NPATH-1:0] bit_d, bit_q;
  dmode_e           mode_e;

  dam_reset_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n));

  dam_phase_acc #(.W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_core_n), .step(fcw), .phase(phase));

  dam_lfsr #(.W(DW), .TAPS(DITH_TAPS[DW-1:0]), .SEED(SEED_A[DW-1:0])) u_lfsr_a (
    .clk(clk), .rst_n(rst_core_n), .state(lfsr_a_state));

  dam_lfsr #(.W(DW), .TAPS(DITH_TAPS[DW-1:0]), .SEED(SEED_B[DW-1:0])) u_lfsr_b (
    .clk(clk), .rst_n(rst_core_n), .state(lfsr_b_state));

  // Offset and dither selection per path
  always_comb begin
    mode_e = dmode_e'(mode);
    off_sel[0]  = phase_off;
    off_sel[1]  = ACC_W'(0) - phase_off;
    dith_sel[0] = lfsr_a_state;
    dith_sel[1] = ~lfsr_a_state;
    case (mode_e)
      MODE_INDEP: dith_sel[1] = lfsr_b_state;
      MODE_SIMPLE: begin
        off_sel[0]  = '0;
        off_sel[1]  = phase_off;
        dith_sel[1] = lfsr_a_state;
      end
      MODE_PLAIN: begin
        dith_sel[0] = '0;
        dith_sel[1] = '0;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    dam_path #(.W(ACC_W)) u_path (
      .phase(phase), .offset(off_sel[g]), .dither(dith_sel[g]), .bit_o(bit_d[g]));
  end

  // Both outputs share one register stage
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) bit_q <= '0;
    else             bit_q <= bit_d;
  end

  assign out_a = bit_q[0];
  assign out_b = bit_q[1];
endmodule

// File: rtl/dam_sva_chk.sv
module dam_sva_chk #(
  parameter int unsigned ACC_W = 16
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic [1:0]       mode,
  input logic [ACC_W-1:0] phase_off,
  input logic [ACC_W-2:0] lfsr_a_state,
  input logic [ACC_W-2:0] lfsr_b_state,
  input logic             out_a,
  input logic             out_b
);
  // R1: outputs held low while the core is in reset
  always @(negedge clk) begin
    if (rst_core_n === 1'b0)
      a_r1_reset_low: assert (!out_a && !out_b);
  end

  // R3: undithered with zero offset gives identical paths
  a_r3_plain_zero_equal: assert property (@(posedge clk) disable iff (rst_core_n !== 1'b1)
    (mode == 2'd3 && phase_off == '0) |=> (out_a == out_b));

  // R7: simple mode with zero offset gives identical paths
  a_r7_simple_zero_equal: assert property (@(posedge clk) disable iff (rst_core_n !== 1'b1)
    (mode == 2'd2 && phase_off == '0) |=> (out_a == out_b));

  // R4: generators never lock up in the all-zero state
  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst_core_n !== 1'b1)
    (lfsr_a_state != '0) && (lfsr_b_state != '0));

  // R4: the two dither streams never coincide
  a_r4_streams_apart: assert property (@(posedge clk) disable iff (rst_core_n !== 1'b1)
    lfsr_a_state != lfsr_b_state);
endmodule

bind diffphase_am_synth dam_sva_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .mode(mode), .phase_off(phase_off),
  .lfsr_a_state(lfsr_a_state), .lfsr_b_state(lfsr_b_state),
  .out_a(out_a), .out_b(out_b));

// File: tb/diffphase_am_synth_tb.sv
`timescale 1ns/1ps
module diffphase_am_synth_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fcw = '0, phase_off = '0;
  logic [1:0]  mode = 2'd3;
  logic        out_a, out_b;

  int errors = 0, checks = 0;

  // reference model state
  logic [15:0] m_acc;
  logic [14:0] m_la, m_lb;

  diffphase_am_synth u_dut (.clk(clk), .rst_n(rst_n), .fcw(fcw), .phase_off(phase_off),
    .mode(mode), .out_a(out_a), .out_b(out_b));

  always #5 clk = ~clk;

  // {mode, fcw, d, cycles}
  localparam logic [49:0] VEC [10] = '{
    {2'd3, 16'h0000, 16'h4000, 16'd4},
    {2'd3, 16'h0000, 16'h8000, 16'd4},
    {2'd3, 16'h1000, 16'h0000, 16'd40},
    {2'd3, 16'h0123, 16'h2000, 16'd60},
    {2'd0, 16'h0400, 16'h1800, 16'd80},
    {2'd0, 16'h0000, 16'h0000, 16'd20},
    {2'd1, 16'h0777, 16'h3000, 16'd80},
    {2'd2, 16'h0400, 16'h6000, 16'd80},
    {2'd2, 16'h0ABC, 16'h0000, 16'd40},
    {2'd0, 16'hFFFF, 16'h7FFF, 16'd40}
  };

  function automatic logic [14:0] lstep(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out_a/out_b actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async", {out_a, out_b}, 2'b00);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 sync edge1", {out_a, out_b}, 2'b00);
    @(posedge clk); @(negedge clk);
    check("R1 sync edge2", {out_a, out_b}, 2'b00);
    m_acc = '0; m_la = 15'h2ACE; m_lb = 15'h1D87;
  endtask

  // one active edge: compare outputs to the model, then advance it
  task automatic step();
    logic [15:0] pa, pb;
    string tag;
    @(posedge clk); @(negedge clk);
    case (mode)
      2'd0: begin pa = m_acc + phase_off + {1'b0, m_la}; pb = m_acc - phase_off + {1'b0, ~m_la}; tag = "R5 mirrored"; end
      2'd1: begin pa = m_acc + phase_off + {1'b0, m_la}; pb = m_acc - phase_off + {1'b0, m_lb}; tag = "R6 independent"; end
      2'd2: begin pa = m_acc + {1'b0, m_la}; pb = m_acc + phase_off + {1'b0, m_la}; tag = "R7 simple"; end
      default: begin pa = m_acc + phase_off; pb = m_acc - phase_off; tag = "R3 undithered"; end
    endcase
    check({tag, " R2 R4"}, {out_a, out_b}, {pa[15], pb[15]});
    m_acc = m_acc + fcw; m_la = lstep(m_la); m_lb = lstep(m_lb);
  endtask

  initial begin
    #(10ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int v = 0; v < 10; v++) begin
      mode = VEC[v][49:48]; fcw = VEC[v][47:32]; phase_off = VEC[v][31:16];
      do_reset();
      for (int c = 0; c < int'(VEC[v][15:0]); c++) step();
    end

    // R8: mid-run offset change is seen only after the next edge
    mode = 2'd3; fcw = 16'h0000; phase_off = 16'h4000;
    do_reset();
    step(); step();
    phase_off = 16'hC000;
    #1 check("R8 held before edge", {out_a, out_b}, 2'b01);
    step();
    check("R8 new value after edge", {out_a, out_b}, 2'b10);

    // R9: mode and fcw changes mid-run keep phase and generators running
    fcw = 16'h0321; phase_off = 16'h1234;
    for (int c = 0; c < 20; c++) step();
    mode = 2'd0;
    for (int c = 0; c < 30; c++) step();
    mode = 2'd1; fcw = 16'h0F0F;
    for (int c = 0; c < 30; c++) step();
    mode = 2'd2;
    for (int c = 0; c < 30; c++) step();

    // R1: reset asserted between edges clears outputs at once
    mode = 2'd3; fcw = 16'h0000; phase_off = 16'h8000;
    step();
    check("R1 pre-reset high", {out_a, out_b}, 2'b11);
    #2 rst_n = 1'b0;
    #1 check("R1 mid-cycle async", {out_a, out_b}, 2'b00);
    do_reset();
    step();
    check("R1 after re-release", {out_a, out_b}, 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule